// File: doc/BRIEF.md
# Bit-Field Place Unit

This block writes a short bit field into a 32-bit destination word. The destination word arrives on one input. A second word carries two things at once: the field data in its low bits, and a small configuration in its upper half that gives the field length and the bit offset where the field goes. The output is the destination word with that window replaced by the field bits. The unit is purely combinational, so the result is valid in the same cycle as the operands.

Inside, a control stage decodes the configuration and builds the field mask. It does this by shifting ones into an all-zero word, once per set bit of the length. A datapath stage then runs the mask and the masked field data through one shared log-stage barrel shifter to the requested offset, and merges the result into the destination. The shifter has its own copy in this unit and is not shared with any other operation. Field bits that would be shifted above bit 31 are dropped.

Top module: `bitFieldPlace`

## Requirements
- R1: The field length is taken from `opB[27:24]` (0 to 15) and the offset from `opB[20:16]` (0 to 31). Bits `opB[31:28]` and `opB[23:21]` have no effect on the result.
- R2: The field mask has exactly `len` low bits set, and the field data is `opB[len-1:0]`.
- R3: For every i with 0 <= i < len and off+i <= 31, result bit off+i equals `opB[i]`.
- R4: When the length is zero, the result equals `opA` for any offset.
- R5: Every result bit outside the window [off, off+len-1] equals the matching bit of `opA`.
- R6: Field bits that would land above bit 31 are discarded. They do not wrap to low bit positions.
- R7: The result depends only on the present operands and settles within the same cycle, with no stored state.
- R8: With offset 31 and a non-zero length, only bit 31 changes, and it takes the value `opB[0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | Destination word |
| opB | input | 32 | Field data in the low bits, length in [27:24], offset in [20:16] |
| result | output | 32 | Destination word with the field placed |

## Verification
On every change of the operands, the bound checker confirms four things. A zero length leaves the destination unchanged. Bits outside the window never differ from `opA`. A field at offset 0 matches `opB`'s low bits. At offset 31 only the top bit changes. What the bench's scenarios alone can show is the full bit-exact result against a behavioural model. That covers the spill-past-31 cases at every offset, the independence from the unused configuration bits, and random operand patterns.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
  parameter int XLEN    = 32;
  parameter int LEN_W   = 4;
  parameter int OFF_W   = 5;
  parameter int LEN_POS = 24;
  parameter int OFF_POS = 16;

  // Strobes handed from control to datapath
  typedef struct packed {
    logic [XLEN-1:0]  fieldMask;  // len low ones, unshifted
    logic [XLEN-1:0]  fieldData;  // opB masked to the field
    logic [OFF_W-1:0] shiftAmt;   // placement offset
  } bfpCtrl_t;
endpackage

// File: rtl/bfpCtrl.sv
module bfpCtrl
  import bfp_pkg::*;
#(
  parameter int W      = XLEN,
  parameter int LW     = LEN_W,
  parameter int OW     = OFF_W,
  parameter int LPOS   = LEN_POS,
  parameter int OPOS   = OFF_POS
) (
  input  logic [W-1:0] opB,
  output bfpCtrl_t     ctrl
);
  logic [LW-1:0] lenVal;
  logic [OW-1:0] offVal;
  assign lenVal = opB[LPOS +: LW];
  assign offVal = opB[OPOS +: OW];

  // Shift-left-ones of zero by len, one stage per length bit
  logic [W-1:0] maskStage [0:LW];
  assign maskStage[0] = '0;

  genvar s;
  generate
    for (s = 0; s < LW; s++) begin : g_maskStage
      localparam int STEP = 1 << s;
      localparam logic [W-1:0] FILL = (W)'((64'h1 << STEP) - 64'h1);
      assign maskStage[s+1] = lenVal[s] ? ((maskStage[s] << STEP) | FILL)
                                        : maskStage[s];
    end
  endgenerate

  assign ctrl.fieldMask = maskStage[LW];
  assign ctrl.fieldData = opB & maskStage[LW];
  assign ctrl.shiftAmt  = offVal;
endmodule

// File: rtl/bfpDatapath.sv
module bfpDatapath
  import bfp_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int OW = OFF_W
) (
  input  logic [W-1:0] opA,
  input  bfpCtrl_t     ctrl,
  output logic [W-1:0] result
);
  // One barrel shifter carries mask and data side by side
  logic [2*W-1:0] laneStage [0:OW];
  assign laneStage[0] = {ctrl.fieldMask, ctrl.fieldData};

  genvar s;
  generate
    for (s = 0; s < OW; s++) begin : g_shiftStage
      localparam int STEP = 1 << s;
      logic [W-1:0] hiLane, loLane;
      assign hiLane = laneStage[s][2*W-1:W];
      assign loLane = laneStage[s][W-1:0];
      assign laneStage[s+1] = ctrl.shiftAmt[s]
                              ? {hiLane << STEP, loLane << STEP}
                              : laneStage[s];
    end
  endgenerate

  logic [W-1:0] placedMask, placedData;
  assign placedMask = laneStage[OW][2*W-1:W];
  assign placedData = laneStage[OW][W-1:0];

  assign result = (opA & ~placedMask) | placedData;
endmodule

// File: rtl/bitFieldPlace.sv
module bitFieldPlace
  import bfp_pkg::*;
(
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  output logic [31:0] result
);
  bfpCtrl_t ctrlBus;

  bfpCtrl #(
    .W(XLEN), .LW(LEN_W), .OW(OFF_W), .LPOS(LEN_POS), .OPOS(OFF_POS)
  ) u_ctrl (
    .opB  (opB),
    .ctrl (ctrlBus)
  );

  bfpDatapath #(
    .W(XLEN), .OW(OFF_W)
  ) u_dp (
    .opA    (opA),
    .ctrl   (ctrlBus),
    .result (result)
  );
endmodule

// File: rtl/bfpChecker.sv
module bfpChecker (
  input logic [31:0] opA,
  input logic [31:0] opB,
  input logic [31:0] result
);
  logic [3:0]  lenC;
  logic [4:0]  offC;
  logic [31:0] diffA, diffB, lowWin, fieldOnes;
  assign lenC      = opB[27:24];
  assign offC      = opB[20:16];
  assign diffA     = result ^ opA;
  assign diffB     = result ^ opB;
  assign lowWin    = (32'h1 << offC) - 32'h1;
  assign fieldOnes = (32'h1 << lenC) - 32'h1;

  always_comb begin
    if (!$isunknown({opA, opB, result})) begin
      p_len_zero_r4: assert (lenC != 4'd0 || result == opA)
        else $error("R4 violated");
      p_outside_window_r5: assert ((diffA & lowWin) == 32'h0 &&
                                   ((diffA >> offC) >> lenC) == 32'h0)
        else $error("R5 violated");
      p_field_at_zero_r3: assert (offC != 5'd0 || (diffB & fieldOnes) == 32'h0)
        else $error("R3 violated");
      p_top_only_r8: assert (offC != 5'd31 || lenC == 4'd0 ||
                             (result[30:0] == opA[30:0] && result[31] == opB[0]))
        else $error("R8 violated");
    end
  end
endmodule

bind bitFieldPlace bfpChecker u_chk (
  .opA    (opA),
  .opB    (opB),
  .result (result)
);

// File: tb/sim_bitFieldPlace.sv
`timescale 1ns/1ps
module sim_bitFieldPlace;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] opA, opB, result;
  int nRun = 0, nFail = 0;
  bit done = 1'b0;

  bitFieldPlace u0 (.opA(opA), .opB(opB), .result(result));

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] m;
    m = (32'h1 << b[27:24]) - 32'h1;
    return (a & ~(m << b[20:16])) | ((b & m) << b[20:16]);
  endfunction

  function automatic logic [31:0] mkB(input logic [31:0] data, input int len, input int off);
    return (data & 32'h0000_FFFF) | (32'(len & 15) << 24) | (32'(off & 31) << 16);
  endfunction

  task automatic apply(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    opA = a; opB = b;
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] exp);
    nRun++;
    if (result !== exp) begin
      nFail++;
      $display("FAIL %s: opA=%h opB=%h got %h expected %h", req, opA, opB, result, exp);
    end
  endtask

  // R7: all-zero operands give zero at once
  task automatic tIdle();
    apply(32'h0, 32'h0);
    check("R7", 32'h0);
  endtask

  // R4: zero length leaves opA unchanged at any offset
  task automatic tZeroLen();
    for (int o = 0; o < 32; o += 7) begin
      apply(32'hDEAD_BEEF, mkB(32'hFFFF, 0, o));
      check("R4", 32'hDEAD_BEEF);
    end
  endtask

  // R2 R3 R5: hand-computed placements
  task automatic tBasic();
    apply(32'h0000_0000, mkB(32'h0005, 4, 8));
    check("R3", 32'h0000_0500);
    apply(32'hFFFF_FFFF, mkB(32'h0000, 8, 4));
    check("R5", 32'hFFFF_F00F);
    apply(32'h1234_5678, mkB(32'hFFFF, 15, 0));
    check("R2", 32'h1234_7FFF);
  endtask

  // R6 R8: fields running past bit 31
  task automatic tSpill();
    apply(32'h0000_0000, mkB(32'h7FFF, 15, 31));
    check("R8", 32'h8000_0000);
    apply(32'hFFFF_FFFF, mkB(32'h7FFE, 15, 31));
    check("R8", 32'h7FFF_FFFF);
    apply(32'h0000_00FF, mkB(32'h00FF, 8, 28));
    check("R6", 32'hF000_00FF);
    apply(32'hAAAA_AAAA, mkB(32'h0000, 12, 24));
    check("R6", 32'h00AA_AAAA);
  endtask

  // R1: unused configuration bits have no effect
  task automatic tIgnored();
    logic [31:0] b;
    b = mkB(32'h0ABC, 12, 5);
    apply(32'h5555_5555, b);
    check("R1", model(32'h5555_5555, b));
    apply(32'h5555_5555, b | 32'hF0E0_0000);
    check("R1", model(32'h5555_5555, b));
  endtask

  // R2 R3 R5 R6: random operands against the model
  task automatic tRandom();
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = $urandom;
      apply(a, b);
      check("R3", model(a, b));
    end
  endtask

  initial begin
    opA = '0; opB = '0;
    void'($urandom(32'd17));
    repeat (2) @(posedge clk);
    tIdle();
    tZeroLen();
    tBasic();
    tSpill();
    tIgnored();
    tRandom();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        nRun++; nFail++;
        $display("FAIL R7: watchdog expired got hang expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule